// File: doc/BRIEF.md
# Linked-list DMA descriptor sequencer

This block steers a scatter-gather transfer whose buffers are described by a chain of descriptors held in memory. Software programs a base address, a first buffer address, a first buffer size and a link word, then pulses `start`. The first buffer runs straight from those registers. When the data path reports that a buffer has finished, the sequencer reads the link word. If the link word says a further item follows, the sequencer reads that item from memory over a single-outstanding read port, reloads its registers from it, checks the item's ready flag and launches the next buffer.

Each descriptor is three words at base plus offset: word 0 is the image of the link word, word 1 is the buffer address and word 2 is the buffer size. The link word that points at an item decides whether that item's size word is read. The chain ends with a done indication when a link word marks the last item. It ends with an error when a loaded item is not ready or when the memory returns a read error. Both end states hold until the next start.

Top module: `lldma_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `buf_go` and `mem_req` are 0, and `link_word`, `buf_addr` and `buf_size` are 0.
- R2: A `start` pulse while not busy launches the first buffer from the programmed registers in the next cycle (`buf_go` = 1, `busy` = 1). The ready flag is not checked for this buffer.
- R3: The link word keeps bit 31 (more items follow), bit 30 (reload size) and bit 29 (item ready), plus the offset in bits OFS_W-1:2. All other bits, including bits 1:0, read as 0.
- R4: When a buffer ends with link bit 31 = 1, the sequencer reads word 0 at base+offset, word 1 at base+offset+4 and, if needed, word 2 at base+offset+8. The base has its bits 1:0 forced to 0. Word 0 replaces the link word and word 1 replaces `buf_addr`.
- R5: When a buffer ends with link bit 31 = 0, no read is made and `done` rises in the next cycle. `done` holds until a new `start`.
- R6: Word 2 is read into `buf_size` (its low SW bits) only when bit 30 of the link word that pointed at the item was 1. Otherwise `buf_size` keeps its value and only two reads are made.
- R7: A loaded item whose bit 29 is 0 moves the sequencer to the error state: `err` = 1 and `buf_go` stays 0. `err` holds until a new `start`.
- R8: A read completed with `mem_err` = 1 moves the sequencer to the error state without loading that word.
- R9: Configuration writes are accepted only while `busy` is 0. `cfg_sel` selects 0 = link word, 1 = base, 2 = buffer address, 3 = buffer size. Writes made while busy have no effect.
- R10: `mem_req` stays 1 with a stable `mem_addr` until the cycle in which `mem_valid` is 1. Only one read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 link, 1 base, 2 buffer address, 3 buffer size |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Start pulse |
| buf_done | input | 1 | Current buffer finished, from the data path |
| buf_go | output | 1 | Current buffer may be moved |
| busy | output | 1 | Chain in progress |
| done | output | 1 | Chain ended at a last item |
| err | output | 1 | Chain aborted |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read byte address |
| mem_valid | input | 1 | Read response valid |
| mem_err | input | 1 | Read response carries an error |
| mem_rdata | input | 32 | Read response data |
| buf_addr | output | AW | Current buffer address |
| buf_size | output | SW | Current buffer size |
| link_word | output | 32 | Current link word |

## Verification
On every cycle, the assertions check several properties. The read request holds steady until it is answered. A start from rest always raises `buf_go`. A last item always leads to `done` without a read. An unready item or a read error always leads to `err`. The link word never moves because of a write made while busy. Whether whole chains load the right words in the right order can only be shown by the bench's scenarios. This covers size reloads that follow the pointing item's flag and not the loaded one's, the number of reads per item, the final address and size, and the effect of a nonzero base.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_RUN, ST_FLINK, ST_FADDR, ST_FSIZE, ST_CHECK, ST_DONE, ST_ERR
    } seq_state_e;

    localparam int LNK_MORE = 31;
    localparam int LNK_SIZE = 30;
    localparam int LNK_RDY  = 29;

    localparam logic [1:0] SEL_LINK  = 2'd0;
    localparam logic [1:0] SEL_BASE  = 2'd1;
    localparam logic [1:0] SEL_BADDR = 2'd2;
    localparam logic [1:0] SEL_BSIZE = 2'd3;
endpackage

// File: rtl/lldma_linkreg.sv
module lldma_linkreg #(
    parameter int OFS_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_we,
    input  logic [31:0] sw_data,
    input  logic        hw_we,
    input  logic [31:0] hw_data,
    output logic [31:0] link_o
);
    localparam logic [31:0] KEEP = {3'b111, {(29-OFS_W){1'b0}}, {(OFS_W-2){1'b1}}, 2'b00};

    logic [31:0] link_d, link_q;

    always_comb begin
        link_d = link_q;
        if (hw_we)      link_d = hw_data & KEEP;
        else if (sw_we) link_d = sw_data & KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) link_q <= '0;
        else        link_q <= link_d;
    end

    assign link_o = link_q;

    // R9: software is gated while the chain runs, so it never meets a descriptor load
    assert_one_writer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_we && sw_we));
endmodule

// File: rtl/lldma_bufregs.sv
module lldma_bufregs #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_we_base,
    input  logic          sw_we_addr,
    input  logic          sw_we_size,
    input  logic [31:0]   sw_data,
    input  logic          hw_we_addr,
    input  logic          hw_we_size,
    input  logic [31:0]   hw_data,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] addr_o,
    output logic [SW-1:0] size_o
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] addr;
        logic [SW-1:0] size;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sw_we_base) r_d.base = {sw_data[AW-1:2], 2'b00};
        if (hw_we_addr)      r_d.addr = hw_data[AW-1:0];
        else if (sw_we_addr) r_d.addr = sw_data[AW-1:0];
        if (hw_we_size)      r_d.size = hw_data[SW-1:0];
        else if (sw_we_size) r_d.size = sw_data[SW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base_o = r_q.base;
    assign addr_o = r_q.addr;
    assign size_o = r_q.size;

    // R6: a descriptor never reloads the size in the same cycle as the address
    assert_size_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_we_addr && hw_we_size));
endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
    import lldma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SW    = 16,
    parameter int OFS_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          start,
    input  logic          buf_done,
    output logic          buf_go,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic          mem_err,
    input  logic [31:0]   mem_rdata,
    output logic [AW-1:0] buf_addr,
    output logic [SW-1:0] buf_size,
    output logic [31:0]   link_word
);
    localparam logic [AW-1:0] W1_OFS = AW'(4);
    localparam logic [AW-1:0] W2_OFS = AW'(8);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] ptr;
        logic          uls;
    } seq_t;

    seq_t s_d, s_q;
    logic link_hw_we, addr_hw_we, size_hw_we;
    logic cfg_ok;
    logic [AW-1:0] base_addr;

    assign cfg_ok = cfg_we && !busy;

    lldma_linkreg #(.OFS_W(OFS_W)) u_link (
        .clk(clk), .rst_n(rst_n),
        .sw_we(cfg_ok && cfg_sel == SEL_LINK), .sw_data(cfg_wdata),
        .hw_we(link_hw_we), .hw_data(mem_rdata),
        .link_o(link_word)
    );

    lldma_bufregs #(.AW(AW), .SW(SW)) u_bufs (
        .clk(clk), .rst_n(rst_n),
        .sw_we_base(cfg_ok && cfg_sel == SEL_BASE),
        .sw_we_addr(cfg_ok && cfg_sel == SEL_BADDR),
        .sw_we_size(cfg_ok && cfg_sel == SEL_BSIZE),
        .sw_data(cfg_wdata),
        .hw_we_addr(addr_hw_we), .hw_we_size(size_hw_we), .hw_data(mem_rdata),
        .base_o(base_addr), .addr_o(buf_addr), .size_o(buf_size)
    );

    always_comb begin
        s_d        = s_q;
        link_hw_we = 1'b0;
        addr_hw_we = 1'b0;
        size_hw_we = 1'b0;
        mem_req    = 1'b0;
        mem_addr   = s_q.ptr;
        case (s_q.st)
            ST_IDLE, ST_DONE, ST_ERR: begin
                if (start) s_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (buf_done) begin
                    if (link_word[LNK_MORE]) begin
                        s_d.st  = ST_FLINK;
                        s_d.ptr = base_addr + AW'(link_word[OFS_W-1:0]);
                        s_d.uls = link_word[LNK_SIZE];
                    end else begin
                        s_d.st = ST_DONE;
                    end
                end
            end
            ST_FLINK: begin
                mem_req = 1'b1;
                if (mem_valid) begin
                    if (mem_err) s_d.st = ST_ERR;
                    else begin
                        link_hw_we = 1'b1;
                        s_d.st     = ST_FADDR;
                    end
                end
            end
            ST_FADDR: begin
                mem_req  = 1'b1;
                mem_addr = s_q.ptr + W1_OFS;
                if (mem_valid) begin
                    if (mem_err) s_d.st = ST_ERR;
                    else begin
                        addr_hw_we = 1'b1;
                        s_d.st     = s_q.uls ? ST_FSIZE : ST_CHECK;
                    end
                end
            end
            ST_FSIZE: begin
                mem_req  = 1'b1;
                mem_addr = s_q.ptr + W2_OFS;
                if (mem_valid) begin
                    if (mem_err) s_d.st = ST_ERR;
                    else begin
                        size_hw_we = 1'b1;
                        s_d.st     = ST_CHECK;
                    end
                end
            end
            ST_CHECK: begin
                s_d.st = link_word[LNK_RDY] ? ST_RUN : ST_ERR;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, ptr: '0, uls: 1'b0};
        else        s_q <= s_d;
    end

    assign buf_go = (s_q.st == ST_RUN);
    assign busy   = (s_q.st != ST_IDLE) && (s_q.st != ST_DONE) && (s_q.st != ST_ERR);
    assign done   = (s_q.st == ST_DONE);
    assign err    = (s_q.st == ST_ERR);

    assert_first_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (buf_go && busy));

    assert_last_item_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_go && buf_done && !link_word[LNK_MORE]) |=> (done && !mem_req));

    assert_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_CHECK && !link_word[LNK_RDY]) |=> (err && !buf_go));

    assert_read_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && mem_err) |=> err);

    assert_cfg_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we && cfg_sel == SEL_LINK && !(mem_req && mem_valid)) |=> $stable(link_word));

    assert_hold_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: tb/sim_lldma_seq.sv
module sim_lldma_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        buf_done = 1'b0;
    logic        buf_go, busy, done, err, mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic        mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] buf_addr;
    logic [15:0] buf_size;
    logic [31:0] link_word;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int bufs_seen = 0;
    int reads_seen = 0;
    int gap = 0;
    int lat = 0;
    logic auto_go = 1'b1;
    logic inj_err = 1'b0;
    logic [31:0] first_addr = '0;
    logic [31:0] mem [64];

    always #4 clk = ~clk;

    lldma_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .start(start), .buf_done(buf_done), .buf_go(buf_go), .busy(busy), .done(done), .err(err),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .buf_addr(buf_addr), .buf_size(buf_size), .link_word(link_word)
    );

    // memory model: answers each held request after two cycles
    always @(negedge clk) begin
        if (mem_valid) begin
            mem_valid <= 1'b0;
            mem_err   <= 1'b0;
            lat       <= 0;
        end else if (mem_req) begin
            if (lat == 1) begin
                mem_valid <= 1'b1;
                mem_err   <= inj_err;
                mem_rdata <= mem[mem_addr[7:2]];
                if (reads_seen == 0) first_addr <= mem_addr;
                reads_seen <= reads_seen + 1;
                lat <= 0;
            end else lat <= lat + 1;
        end
    end

    // data path model: finishes each buffer a few cycles after it is granted
    always @(negedge clk) begin
        if (buf_done) buf_done <= 1'b0;
        else if (buf_go && auto_go) begin
            if (gap == 2) begin
                buf_done  <= 1'b1;
                bufs_seen <= bufs_seen + 1;
                gap       <= 0;
            end else gap <= gap + 1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int i = 0; i < 2000; i++) begin
            if (done || err) break;
            @(negedge clk);
        end
    endtask

    task automatic launch(input logic [31:0] link0, input logic [31:0] base);
        cfg_write(2'd1, base);
        cfg_write(2'd2, 32'h0000_1000);
        cfg_write(2'd3, 32'h0000_00FF);
        cfg_write(2'd0, link0);
        @(negedge clk);
        bufs_seen = 0; reads_seen = 0;
        pulse_start();
    endtask

    typedef struct packed {
        logic [31:0] link0;
        logic        exp_err;
        logic [3:0]  bufs;
        logic [3:0]  reads;
        logic [31:0] addr;
        logic [15:0] size;
        logic [31:0] link;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{32'h0000_0000, 1'b0, 4'd1, 4'd0, 32'h0000_1000, 16'h00FF, 32'h0000_0000},
        '{32'h8000_0010, 1'b0, 4'd2, 4'd2, 32'hA000_0000, 16'h00FF, 32'h2000_0000},
        '{32'hC000_0010, 1'b0, 4'd2, 4'd3, 32'hA000_0000, 16'h0111, 32'h2000_0000},
        '{32'h8000_0020, 1'b0, 4'd3, 4'd5, 32'hA000_0000, 16'h0111, 32'h2000_0000},
        '{32'hC000_0030, 1'b0, 4'd4, 4'd8, 32'hA000_0000, 16'h0111, 32'h2000_0000},
        '{32'h8000_0040, 1'b1, 4'd1, 4'd2, 32'hD000_0000, 16'h00FF, 32'h0000_0000},
        '{32'h8000_0050, 1'b0, 4'd2, 4'd2, 32'hE000_0000, 16'h00FF, 32'h2000_0000}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[4]  = 32'h2000_0000; mem[5]  = 32'hA000_0000; mem[6]  = 32'h0000_0111;
        mem[8]  = 32'hE000_0010; mem[9]  = 32'hB000_0000; mem[10] = 32'h0000_0222;
        mem[12] = 32'hA000_0020; mem[13] = 32'hC000_0000; mem[14] = 32'h0000_0333;
        mem[16] = 32'h0000_0000; mem[17] = 32'hD000_0000; mem[18] = 32'h0000_0444;
        mem[20] = 32'h2000_0000; mem[21] = 32'hE000_0000; mem[22] = 32'h0000_0555;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !err, "R1 status", {29'd0, busy, done, err}, 32'd0);
        check(!buf_go && !mem_req, "R1 outputs", {30'd0, buf_go, mem_req}, 32'd0);
        check(link_word == 32'd0, "R1 link", link_word, 32'd0);
        check(buf_addr == 32'd0, "R1 addr", buf_addr, 32'd0);
        check(buf_size == 16'd0, "R1 size", {16'd0, buf_size}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 field masking
        cfg_write(2'd0, 32'h9FFF_FFFF);
        check(link_word == 32'h8000_FFFC, "R3 mask", link_word, 32'h8000_FFFC);

        // R2 first buffer launches from registers, ready bit 0 ignored
        auto_go = 1'b0;
        launch(32'h0000_0000, 32'h0);
        check(buf_go && busy, "R2 first go", {30'd0, buf_go, busy}, 32'd3);
        check(buf_addr == 32'h0000_1000, "R2 first addr", buf_addr, 32'h0000_1000);
        // R9 writes while busy ignored
        cfg_write(2'd0, 32'h8000_0010);
        cfg_write(2'd3, 32'h0000_00AB);
        check(link_word == 32'h0, "R9 link locked", link_word, 32'h0);
        check(buf_size == 16'h00FF, "R9 size locked", {16'd0, buf_size}, 32'h0000_00FF);
        auto_go = 1'b1;
        wait_end();
        check(done && !err, "R5 done", {30'd0, done, err}, 32'd2);
        repeat (5) @(negedge clk);
        check(done && reads_seen == 0, "R5 done holds", {31'd0, done}, 32'd1);

        // table of chains: R4 R5 R6 R7
        for (int v = 0; v < 7; v++) begin
            launch(VECS[v].link0, 32'h0);
            wait_end();
            check(err == VECS[v].exp_err && done == !VECS[v].exp_err, "R5/R7 end state",
                  {30'd0, done, err}, {30'd0, !VECS[v].exp_err, VECS[v].exp_err});
            check(bufs_seen == int'(VECS[v].bufs), "R4/R7 buffers", bufs_seen, {28'd0, VECS[v].bufs});
            check(reads_seen == int'(VECS[v].reads), "R6 reads", reads_seen, {28'd0, VECS[v].reads});
            check(buf_addr == VECS[v].addr, "R4 addr", buf_addr, VECS[v].addr);
            check(buf_size == VECS[v].size, "R6 size", {16'd0, buf_size}, {16'd0, VECS[v].size});
            check(link_word == VECS[v].link, "R4 link", link_word, VECS[v].link);
        end

        // R7 error holds, then a new start clears it
        repeat (5) @(negedge clk);
        launch(32'h8000_0040, 32'h0);
        wait_end();
        repeat (5) @(negedge clk);
        check(err && !buf_go, "R7 err holds", {30'd0, err, buf_go}, 32'd2);
        launch(32'h0000_0000, 32'h0);
        check(busy && !err, "R7 cleared by start", {30'd0, busy, err}, 32'd2);
        wait_end();

        // R4 nonzero base with low bits dropped
        launch(32'h8000_0030, 32'h0000_0023);
        wait_end();
        check(first_addr == 32'h0000_0050, "R4 base+offset", first_addr, 32'h0000_0050);
        check(buf_addr == 32'hE000_0000, "R4 base addr", buf_addr, 32'hE000_0000);

        // R8 read error
        inj_err = 1'b1;
        launch(32'h8000_0010, 32'h0);
        wait_end();
        inj_err = 1'b0;
        check(err && !done, "R8 err", {30'd0, err, done}, 32'd2);
        check(reads_seen == 1, "R8 one read", reads_seen, 32'd1);
        check(link_word == 32'h8000_0010, "R8 no load", link_word, 32'h8000_0010);

        $display("Simulation finished: %0d checks, %0d errors", checks, fails);
        $finish;
    end
endmodule